// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address. It walks a two-level page table held in memory, which is the Sv32 arrangement. A requester hands over the virtual address together with the current translation control word. The walker then fetches one or two 32-bit table entries through a word-read memory port, decodes each entry, and finally reports:

- the leaf entry it found,
- the level where the walk stopped,
- the translated address, or a not-found result.

A translation control word whose low 22 bits are zero selects bare mode. In that mode the address passes through unchanged and no memory read is made.

Each table entry carries a four-bit type code in its low bits: bit 0 is valid, bit 1 is read, bit 2 is write and bit 3 is execute. The walker stops with not-found in any of these cases:

- the code is one of the reserved codes;
- the valid bit is clear;
- a table page number points outside physical memory;
- a first-level leaf describes a superpage that is not aligned;
- two levels have been read without reaching a leaf.

Permission checks, caching of translations, updates of the accessed and dirty bits, and arbitration for the memory port all belong to the surrounding logic.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready`=1, `done`=0 and `mem_req_valid`=0. A request is accepted only while `req_ready`=1 (idle). `req_ready` stays 0 from the accepting edge until the cycle after `done`.
- R2: If `req_ctrl[21:0]`==0 (bare mode), no memory read is made. `done` rises in the cycle after acceptance, with `res_found`=1, `res_level`=0, `res_pte`=0 and `res_paddr` equal to `req_vaddr` zero-extended.
- R3: The root page number `req_ctrl[21:0]` must be below `MEM_PAGES`. If it is not (and is nonzero), the walk ends with not-found at level 1 and no read is made.
- R4: Each entry read is addressed at page_number*4096 + index*4. Level 1 uses index `vaddr[31:22]` and level 2 uses index `vaddr[21:12]`. `mem_req_valid` holds with a stable address until `mem_req_ready`. Read data is taken at the first `mem_rsp_valid` in a cycle after the handshake.
- R5: An entry whose low nibble is 0001 points to the next table, whose page number is `entry[31:10]`. If that page number is not below `MEM_PAGES`, the walk ends with not-found at level 1.
- R6: The nibbles 0011, 0111, 1001, 1011 and 1111 are leaves. A leaf ends the walk with `res_found`=1, the entry on `res_pte`, and the current level on `res_level`.
- R7: The nibbles 0101 and 1101, and any entry with bit 0 = 0, end the walk with not-found at the current level.
- R8: A level-1 leaf with `entry[19:10]` nonzero is a misaligned superpage and ends the walk with not-found at level 1.
- R9: A level-1 leaf translates to {`entry[31:20]`, `vaddr[21:0]`}. A level-2 leaf translates to {`entry[31:10]`, `vaddr[11:0]`}.
- R10: A pointer entry read at level 2 ends the walk with not-found at level 2.
- R11: `done` is high for exactly one cycle per request, with the results valid in that cycle. On not-found, `res_pte` and `res_paddr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ctrl | input | 32 | Translation control word; low 22 bits are root page number |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 34 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry word |
| done | output | 1 | One-cycle completion pulse |
| res_found | output | 1 | Translation succeeded |
| res_level | output | 2 | 0 bare, 1 or 2 level where the walk ended |
| res_pte | output | 32 | Leaf entry, 0 when not found |
| res_paddr | output | 34 | Physical address, 0 when not found |

## Verification
The bench builds a small page table in a memory model. Into that table it places every leaf code, both reserved codes, an entry with the valid bit clear, an empty slot, pointers to in-range and out-of-range pages, a pointer met at level 2, and both an aligned and a misaligned superpage. This separates decoding by level from decoding by type code, and it checks the page-number bit fields at their widest values. Bare mode, the out-of-range root and the highest in-range root separate the shortcuts taken before any read from a read at the table-page boundary. The memory model adds request and response stalls of zero to three cycles, so the hold of the read request and the wait for its data are each tried on their own.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int VA_W   = 32;
    localparam int PTE_W  = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int PPN_W  = 22;
    localparam int PA_W   = PPN_W + OFF_W;
    localparam int LEVELS = 2;
    localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_RSP  = 2'd2,
        S_DONE = 2'd3
    } walk_state_e;
endpackage

// File: rtl/pw_page_check.sv
module pw_page_check
    import pw_pkg::*;
#(
    parameter int unsigned MEM_PAGES = 1024
) (
    input  logic [PPN_W-1:0] ppn,
    output logic             in_range
);
    always_comb begin
        in_range = ({10'd0, ppn} < 32'(MEM_PAGES));
    end
endmodule

// File: rtl/pw_pte_decode.sv
module pw_pte_decode
    import pw_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    output logic             is_ptr,
    output logic             is_leaf
);
    logic v_b, r_b, w_b, x_b;

    always_comb begin
        v_b = pte[0];
        r_b = pte[1];
        w_b = pte[2];
        x_b = pte[3];
        is_ptr  = v_b && !r_b && !w_b && !x_b;
        is_leaf = v_b && (r_b || x_b) && !(w_b && !r_b);
    end
endmodule

// File: rtl/pw_addr_gen.sv
module pw_addr_gen
    import pw_pkg::*;
(
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PPN_W-1:0] tbl_ppn,
    input  logic [LVL_W-1:0] lvl_idx,
    input  logic [PTE_W-1:0] pte,
    output logic [PA_W-1:0]  entry_addr,
    output logic [PA_W-1:0]  leaf_pa,
    output logic             sp_misaligned
);
    logic [PPN_W-1:0] pte_ppn;
    logic [IDX_W-1:0] idx_l [LEVELS];
    logic [PA_W-1:0]  pa_l  [LEVELS];
    logic             mis_l [LEVELS];

    assign pte_ppn = pte[PTE_W-1 -: PPN_W];

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int KEEP = OFF_W + (LEVELS - 1 - l) * IDX_W;
        localparam logic [PA_W-1:0] MASK = (PA_W'(1) << KEEP) - PA_W'(1);
        assign idx_l[l] = vaddr[KEEP +: IDX_W];
        assign pa_l[l]  = ({pte_ppn, {OFF_W{1'b0}}} & ~MASK) | (PA_W'(vaddr) & MASK);
        if (KEEP > OFF_W) begin : g_super
            assign mis_l[l] = |pte_ppn[KEEP-OFF_W-1:0];
        end else begin : g_page
            assign mis_l[l] = 1'b0;
        end
    end

    always_comb begin
        entry_addr    = {tbl_ppn, {OFF_W{1'b0}}} + PA_W'({idx_l[lvl_idx], 2'b00});
        leaf_pa       = pa_l[lvl_idx];
        sp_misaligned = mis_l[lvl_idx];
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pw_pkg::*;
#(
    parameter int unsigned MEM_PAGES = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_vaddr,
    input  logic [31:0]      req_ctrl,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [33:0]      mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [31:0]      mem_rsp_data,
    output logic             done,
    output logic             res_found,
    output logic [1:0]       res_level,
    output logic [31:0]      res_pte,
    output logic [33:0]      res_paddr
);
    typedef struct packed {
        walk_state_e      st;
        logic [1:0]       lvl;
        logic [VA_W-1:0]  va;
        logic [PPN_W-1:0] tbl;
        logic             found;
        logic [PTE_W-1:0] pte;
        logic [PA_W-1:0]  pa;
    } walk_t;

    walk_t q, d;

    logic             root_ok, next_ok, is_ptr, is_leaf, sp_mis;
    logic [PA_W-1:0]  entry_addr, leaf_pa;
    logic [PPN_W-1:0] root_ppn, next_ppn;
    logic [LVL_W-1:0] lvl_idx;

    assign root_ppn = req_ctrl[PPN_W-1:0];
    assign next_ppn = mem_rsp_data[PTE_W-1 -: PPN_W];
    assign lvl_idx  = LVL_W'(q.lvl - 2'd1);

    pw_page_check #(.MEM_PAGES(MEM_PAGES)) u_root_chk (
        .ppn(root_ppn), .in_range(root_ok)
    );
    pw_page_check #(.MEM_PAGES(MEM_PAGES)) u_next_chk (
        .ppn(next_ppn), .in_range(next_ok)
    );
    pw_pte_decode u_dec (
        .pte(mem_rsp_data), .is_ptr(is_ptr), .is_leaf(is_leaf)
    );
    pw_addr_gen u_agen (
        .vaddr(q.va), .tbl_ppn(q.tbl), .lvl_idx(lvl_idx), .pte(mem_rsp_data),
        .entry_addr(entry_addr), .leaf_pa(leaf_pa), .sp_misaligned(sp_mis)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.va    = req_vaddr;
                    d.found = 1'b0;
                    d.pte   = '0;
                    d.pa    = '0;
                    d.tbl   = root_ppn;
                    if (root_ppn == '0) begin
                        d.st    = S_DONE;
                        d.lvl   = 2'd0;
                        d.found = 1'b1;
                        d.pa    = PA_W'(req_vaddr);
                    end else if (!root_ok) begin
                        d.st  = S_DONE;
                        d.lvl = 2'd1;
                    end else begin
                        d.st  = S_REQ;
                        d.lvl = 2'd1;
                    end
                end
            end
            S_REQ: begin
                if (mem_req_ready) d.st = S_RSP;
            end
            S_RSP: begin
                if (mem_rsp_valid) begin
                    d.st = S_DONE;
                    if (is_leaf) begin
                        if (!sp_mis) begin
                            d.found = 1'b1;
                            d.pte   = mem_rsp_data;
                            d.pa    = leaf_pa;
                        end
                    end else if (is_ptr && (q.lvl < 2'(LEVELS)) && next_ok) begin
                        d.st  = S_REQ;
                        d.tbl = next_ppn;
                        d.lvl = q.lvl + 2'd1;
                    end
                end
            end
            S_DONE: d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready     = (q.st == S_IDLE);
    assign mem_req_valid = (q.st == S_REQ);
    assign mem_req_addr  = entry_addr;
    assign done          = (q.st == S_DONE);
    assign res_found     = q.found;
    assign res_level     = q.lvl;
    assign res_pte       = q.pte;
    assign res_paddr     = q.pa;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R4
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R1
    AST_BARE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_ctrl[21:0] == 22'd0)
        |=> done && res_found && (res_level == 2'd0)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done && !res_found |-> (res_pte == '0) && (res_paddr == '0)); // R11
    AST_LEAF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done && res_found && (res_level != 2'd0)
        |-> res_pte[0] && (res_pte[1] || res_pte[3])); // R6
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
    typedef struct packed {
        logic [31:0] va;
        logic [31:0] ctrl;
        logic        found;
        logic [1:0]  lvl;
        logic [31:0] pte;
        logic [33:0] pa;
        logic [2:0]  reads;
        logic [33:0] addr;
        logic [1:0]  lat;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{32'hDEADBEEF, 32'h80000000, 1'b1, 2'd0, 32'h0,        34'h0DEADBEEF, 3'd0, 34'h0,       2'd0},
        '{32'h00403567, 32'h00000400, 1'b0, 2'd1, 32'h0,        34'h0,         3'd0, 34'h0,       2'd0},
        '{32'h00403567, 32'h00000010, 1'b1, 2'd2, 32'h048D1403, 34'h012345567, 3'd2, 34'h2000C,   2'd0},
        '{32'h00404ABC, 32'h00000010, 1'b1, 2'd2, 32'hFFFFFC09, 34'h3FFFFFABC, 3'd2, 34'h20010,   2'd1},
        '{32'h00405FFF, 32'h00000010, 1'b1, 2'd2, 32'h00001C0B, 34'h000007FFF, 3'd2, 34'h20014,   2'd2},
        '{32'h00406000, 32'h00000010, 1'b1, 2'd2, 32'h00002007, 34'h000008000, 3'd2, 34'h20018,   2'd3},
        '{32'h0089ABCD, 32'h00000010, 1'b1, 2'd1, 32'h0010000F, 34'h00049ABCD, 3'd1, 34'h10008,   2'd1},
        '{32'h00C00000, 32'h00000010, 1'b0, 2'd1, 32'h0,        34'h0,         3'd1, 34'h1000C,   2'd0},
        '{32'h01000000, 32'h00000010, 1'b0, 2'd1, 32'h0,        34'h0,         3'd1, 34'h10010,   2'd2},
        '{32'h01400000, 32'h00000010, 1'b0, 2'd1, 32'h0,        34'h0,         3'd1, 34'h10014,   2'd0},
        '{32'h01800000, 32'h00000010, 1'b0, 2'd1, 32'h0,        34'h0,         3'd1, 34'h10018,   2'd1},
        '{32'h01C00000, 32'h00000010, 1'b0, 2'd2, 32'h0,        34'h0,         3'd2, 34'h21000,   2'd3},
        '{32'h00407000, 32'h00000010, 1'b0, 2'd2, 32'h0,        34'h0,         3'd2, 34'h2001C,   2'd0},
        '{32'h00408000, 32'h00000010, 1'b0, 2'd2, 32'h0,        34'h0,         3'd2, 34'h20020,   2'd1},
        '{32'h00000000, 32'h000003FF, 1'b0, 2'd1, 32'h0,        34'h0,         3'd1, 34'h3FF000,  2'd0},
        '{32'h00000FFF, 32'h00000000, 1'b1, 2'd0, 32'h0,        34'h000000FFF, 3'd0, 34'h0,       2'd0}
    };
    localparam string TAGS [NV] = '{
        "R2 bare", "R3 root range", "R6 R9 RO leaf", "R6 R9 EO leaf max ppn",
        "R6 R9 RX leaf", "R6 R9 RW leaf", "R6 R9 superpage", "R8 misaligned",
        "R7 reserved L1", "R7 invalid L1", "R5 pointer range", "R10 pointer at L2",
        "R7 reserved L2", "R7 empty L2", "R3 R4 root boundary", "R2 bare ctrl zero"
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_ctrl = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [33:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done, res_found;
    logic [1:0]  res_level;
    logic [31:0] res_pte;
    logic [33:0] res_paddr;

    int n_chk = 0;
    int n_bad = 0;
    int rd_cnt = 0;
    int req_lat = 0;
    int rsp_lat = 0;
    logic [33:0] last_addr = '0;
    logic [31:0] pmem [logic [33:0]];

    always #2 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_ctrl(req_ctrl),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .res_found(res_found), .res_level(res_level),
        .res_pte(res_pte), .res_paddr(res_paddr)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // memory model: request and response stalls, one read in flight
    initial begin
        logic        pending = 1'b0;
        int          qcnt = 0;
        int          rcnt = 0;
        logic [33:0] cap = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_ready) begin
                mem_req_ready = 1'b0;
                pending = 1'b1;
                rcnt = 0;
                rd_cnt++;
                last_addr = cap;
            end else if (mem_req_valid && !pending) begin
                if (qcnt >= req_lat) begin
                    mem_req_ready = 1'b1;
                    cap = mem_req_addr;
                    qcnt = 0;
                end else qcnt++;
            end
            if (pending) begin
                if (rcnt >= rsp_lat) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = pmem.exists(cap) ? pmem[cap] : 32'h0;
                    pending = 1'b0;
                end else rcnt++;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    task automatic run_vec(input int i);
        vec_t v = VECS[i];
        int   cyc = 0;
        rd_cnt = 0;
        req_lat = int'(v.lat);
        rsp_lat = int'(v.lat);
        @(negedge clk);
        req_vaddr = v.va;
        req_ctrl  = v.ctrl;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        chk({TAGS[i], " found"}, 64'(res_found), 64'(v.found));
        chk({TAGS[i], " level"}, 64'(res_level), 64'(v.lvl));
        chk({TAGS[i], " pte (R11 zero on miss)"}, 64'(res_pte), 64'(v.pte));
        chk({TAGS[i], " paddr (R9)"}, 64'(res_paddr), 64'(v.pa));
        chk({TAGS[i], " read count"}, 64'(rd_cnt), 64'(v.reads));
        if (v.reads != 0) chk({TAGS[i], " R4 last entry address"}, 64'(last_addr), 64'(v.addr));
        if (v.ctrl[21:0] == 22'd0) chk({TAGS[i], " R2 done next cycle"}, 64'(cyc), 64'd0);
        @(negedge clk);
        chk({TAGS[i], " R11 done one cycle"}, 64'(done), 64'd0);
        chk({TAGS[i], " R1 idle again"}, 64'(req_ready), 64'd1);
    endtask

    initial begin
        // R4 R6: level-1 table at page 0x10
        pmem[34'h10004] = 32'h00008001;
        pmem[34'h10008] = 32'h0010000F;
        pmem[34'h1000C] = 32'h00100403;
        pmem[34'h10010] = 32'h00000005;
        pmem[34'h10014] = 32'h0000800E;
        pmem[34'h10018] = 32'h00140001;
        pmem[34'h1001C] = 32'h00008401;
        // level-2 tables at pages 0x20 and 0x21
        pmem[34'h2000C] = 32'h048D1403;
        pmem[34'h20010] = 32'hFFFFFC09;
        pmem[34'h20014] = 32'h00001C0B;
        pmem[34'h20018] = 32'h00002007;
        pmem[34'h2001C] = 32'h0000000D;
        pmem[34'h21000] = 32'h00008801;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset req_ready", 64'(req_ready), 64'd1);
        chk("R1 reset done", 64'(done), 64'd0);
        chk("R1 reset mem_req_valid", 64'(mem_req_valid), 64'd0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R1: request held high through a walk is not taken again until done
        begin
            int busy_bad = 0;
            int cyc = 0;
            req_lat = 3;
            rsp_lat = 3;
            @(negedge clk);
            req_vaddr = 32'h00403567;
            req_ctrl  = 32'h10;
            req_valid = 1'b1;
            @(negedge clk);
            req_vaddr = 32'h00000FFF;
            req_ctrl  = 32'h0;
            while (!done && cyc < 100) begin
                if (req_ready) busy_bad++;
                @(negedge clk);
                cyc++;
            end
            req_valid = 1'b0;
            chk("R1 req_ready low while walking", 64'(busy_bad), 64'd0);
            chk("R1 held request result paddr", 64'(res_paddr), 64'h012345567);
            @(negedge clk);
            chk("R11 R1 single done for held request", 64'(done), 64'd0);
        end

        // R11: back-to-back requests each give one pulse
        run_vec(6);
        run_vec(0);
        finish_run();
    end
endmodule